// File: doc/BRIEF.md
# Quadrature quarter-cycle sample accumulator

This block performs synchronous I/Q demodulation of one sensor channel against a square-wave reference. Unsigned ADC samples arrive with a qualifying valid signal. A fixed number of accepted samples makes up one modulation cycle, and each cycle is split into four equal quarter-cycle groups. Every group is summed plainly. The four group sums are then weighted by the square-wave signs of the in-phase and quadrature references and added into one signed I value and one signed Q value per cycle.

Once per completed cycle the block presents both values with a one-clock strobe. A downstream stage would average these values over many cycles and form a magnitude from them. This block does neither.

Top module: `quad_group_accum`

## Requirements
- R1: Each of the four groups in a cycle is the plain sum of GROUP_LEN consecutive accepted samples (default 5, so a cycle holds 20 samples). Groups are indexed 0 to 3 in arrival order.
- R2: The I output equals the sum of the group sums weighted by +1 for groups 0 and 1 and by -1 for groups 2 and 3. Group sums 19673, 19484, 20418 and 20475 give I = -1736.
- R3: The Q output equals the sum of the group sums weighted by -1 for groups 0 and 3 and by +1 for groups 1 and 2. The same four group sums give Q = -246.
- R4: strobe_o is high for exactly one clock per cycle, in the clock that follows the acceptance of the cycle's last sample, and it is low at every other time.
- R5: A clock with valid_i low neither advances the sample count nor alters any sum, whatever value sample_i carries.
- R6: Asserting rst_ni low clears both outputs to zero, clears the strobe, and discards any partial cycle, so the next accepted sample is sample 0 of group 0.
- R7: inph_o and quad_o keep their values between strobes.
- R8: With the default widths, full-scale samples (4095) cause no wrap-around. The I and Q outputs reach +/-40950 exactly when two adjacent-weighted groups are at full scale and the other two are at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies sample_i in this clock |
| sample_i | input | SAMPLE_W | Unsigned ADC sample |
| inph_o | output | SAMPLE_W+clog2(GROUP_LEN)+2 | Signed in-phase cycle sum |
| quad_o | output | SAMPLE_W+clog2(GROUP_LEN)+2 | Signed quadrature cycle sum |
| strobe_o | output | 1 | One-clock pulse when a new cycle result is present |

## Verification
The bench builds the block with its default parameters: 12-bit samples and groups of five, which gives the 20-sample cycle and 15-bit group and 17-bit output widths. At these values the bench can replay the known cycle that yields I = -1736 and Q = -246. It can also drive full-scale group patterns that push each output to its positive and negative extremes, and it can exercise every group index with idle gaps of random sample values between accepted samples. A reset in the middle of a cycle is also within reach, and the bench confirms that the following cycle starts cleanly from group 0.

// File: rtl/qga_pkg.sv
package qga_pkg;
  // Square-wave reference signs per group index (1 = subtract)
  function automatic logic i_neg(input logic [1:0] idx);
    return idx[1];
  endfunction

  function automatic logic q_neg(input logic [1:0] idx);
    return idx[1] ~^ idx[0];
  endfunction
endpackage

// File: rtl/qga_group_sum.sv
module qga_group_sum #(
  parameter int SAMPLE_W  = 12,
  parameter int GROUP_LEN = 5,
  parameter int ACC_W     = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                fire_o,
  output logic [1:0]          idx_o,
  output logic [ACC_W-1:0]    sum_o
);
  localparam int CNT_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GROUP_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       idx_q;
  logic [ACC_W-1:0] acc_q;
  logic             last_smp;

  assign last_smp = (cnt_q == CNT_LAST);
  assign fire_o   = valid_i && last_smp;
  assign idx_o    = idx_q;
  assign sum_o    = acc_q + ACC_W'(sample_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      acc_q <= '0;
    end else if (valid_i) begin
      if (last_smp) begin
        cnt_q <= '0;
        idx_q <= idx_q + 2'd1;
        acc_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        acc_q <= sum_o;
      end
    end
  end
endmodule

// File: rtl/qga_path.sv
module qga_path #(
  parameter int ACC_W = 15,
  parameter int OUT_W = 17,
  parameter bit IS_Q  = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fire_i,
  input  logic [1:0]              idx_i,
  input  logic [ACC_W-1:0]        sum_i,
  output logic signed [OUT_W-1:0] cyc_o
);
  import qga_pkg::*;

  logic                    neg;
  logic signed [OUT_W-1:0] ext, wgt, run_q, out_q;

  generate
    if (IS_Q) begin : g_q
      assign neg = q_neg(idx_i);
    end else begin : g_i
      assign neg = i_neg(idx_i);
    end
  endgenerate

  assign ext   = $signed({{(OUT_W-ACC_W){1'b0}}, sum_i});
  assign wgt   = neg ? -ext : ext;
  assign cyc_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      out_q <= '0;
    end else if (fire_i) begin
      if (idx_i == 2'd3) begin
        out_q <= run_q + wgt;
        run_q <= '0;
      end else begin
        run_q <= run_q + wgt;
      end
    end
  end
endmodule

// File: rtl/quad_group_accum.sv
module quad_group_accum #(
  parameter int SAMPLE_W  = 12,
  parameter int GROUP_LEN = 5,
  localparam int ACC_W    = SAMPLE_W + $clog2(GROUP_LEN),
  localparam int OUT_W    = ACC_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  output logic signed [OUT_W-1:0] inph_o,
  output logic signed [OUT_W-1:0] quad_o,
  output logic                    strobe_o
);
  logic             fire;
  logic [1:0]       idx;
  logic [ACC_W-1:0] gsum;
  logic             strobe_q;
  logic signed [OUT_W-1:0] cyc [2];

  qga_group_sum #(
    .SAMPLE_W (SAMPLE_W),
    .GROUP_LEN(GROUP_LEN),
    .ACC_W    (ACC_W)
  ) u_group (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sample_i(sample_i),
    .fire_o  (fire),
    .idx_o   (idx),
    .sum_o   (gsum)
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    qga_path #(
      .ACC_W(ACC_W),
      .OUT_W(OUT_W),
      .IS_Q (p == 1)
    ) u_path (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .fire_i(fire),
      .idx_i (idx),
      .sum_i (gsum),
      .cyc_o (cyc[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= fire && (idx == 2'd3);
  end

  assign inph_o   = cyc[0];
  assign quad_o   = cyc[1];
  assign strobe_o = strobe_q;
endmodule

// File: rtl/quad_group_accum_chk.sv
module quad_group_accum_chk #(
  parameter int SAMPLE_W  = 12,
  parameter int GROUP_LEN = 5,
  parameter int OUT_W     = 17
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic signed [OUT_W-1:0] inph_o,
  input logic signed [OUT_W-1:0] quad_o,
  input logic                    strobe_o
);
  localparam int MAXV = 2 * GROUP_LEN * ((1 << SAMPLE_W) - 1);

  p_strobe_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  p_strobe_after_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(valid_i));

  p_hold_i_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(inph_o));

  p_hold_q_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(quad_o));

  p_range_i_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(inph_o) <= MAXV) && (int'(inph_o) >= -MAXV));

  p_range_q_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(quad_o) <= MAXV) && (int'(quad_o) >= -MAXV));

  // I - Q = 2*(g0 - g2): the two paths always differ by an even amount (R2, R3)
  p_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> !(inph_o[0] ^ quad_o[0]));
endmodule

bind quad_group_accum quad_group_accum_chk #(
  .SAMPLE_W (SAMPLE_W),
  .GROUP_LEN(GROUP_LEN),
  .OUT_W    (OUT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .inph_o  (inph_o),
  .quad_o  (quad_o),
  .strobe_o(strobe_o)
);

// File: tb/quad_group_accum_tb.sv
module quad_group_accum_tb;
  localparam int GL = 5;
  localparam int NS = 4 * GL;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [11:0]        sample_i = '0;
  logic signed [16:0] inph_o, quad_o;
  logic               strobe_o;

  int checks = 0;
  int failures = 0;
  int smp [NS];

  always #2 clk_i = ~clk_i;

  quad_group_accum u_dut (
    .clk_i, .rst_ni, .valid_i, .sample_i, .inph_o, .quad_o, .strobe_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_val(input bit is_q);
    int acc = 0;
    for (int g = 0; g < 4; g++) begin
      int s = 0;
      bit neg;
      for (int k = 0; k < GL; k++) s += smp[g*GL + k];
      neg = is_q ? (g == 0 || g == 3) : (g >= 2);
      acc += neg ? -s : s;
    end
    return acc;
  endfunction

  task automatic run_cycle(input int gap_pct, input string lbl);
    bit early = 0;
    int ei, eq, hi, hq;
    for (int k = 0; k < NS; k++) begin
      while (gap_pct > 0 && int'($urandom_range(99)) < gap_pct) begin
        @(negedge clk_i);
        if (strobe_o) early = 1;
        valid_i  = 1'b0;
        sample_i = 12'($urandom);
      end
      @(negedge clk_i);
      if (strobe_o) early = 1;
      valid_i  = 1'b1;
      sample_i = 12'(smp[k]);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    ei = exp_val(1'b0);
    eq = exp_val(1'b1);
    chk(!early, {"R4 no early strobe ", lbl}, early, 0);
    chk(strobe_o == 1'b1, {"R4 strobe after last sample ", lbl}, strobe_o, 1);
    chk(int'(inph_o) == ei, {"R2 I path ", lbl}, int'(inph_o), ei);
    chk(int'(quad_o) == eq, {"R3 Q path ", lbl}, int'(quad_o), eq);
    hi = int'(inph_o);
    hq = int'(quad_o);
    @(negedge clk_i);
    sample_i = 12'($urandom);
    chk(strobe_o == 1'b0, {"R4 single-clock strobe ", lbl}, strobe_o, 0);
    chk(int'(inph_o) == hi && int'(quad_o) == hq, {"R7 hold ", lbl}, int'(inph_o), hi);
  endtask

  task automatic fill_groups(input int a, input int b, input int c, input int d);
    for (int k = 0; k < GL; k++) begin
      smp[k] = a; smp[GL+k] = b; smp[2*GL+k] = c; smp[3*GL+k] = d;
    end
  endtask

  task automatic load_example();
    int ex [NS] = '{4094, 3893, 3895, 3895, 3896, 3896, 3896, 3898, 3897, 3897,
                    4039, 4094, 4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095};
    for (int k = 0; k < NS; k++) smp[k] = ex[k];
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20170619));
    repeat (3) @(negedge clk_i);
    chk(strobe_o == 1'b0 && inph_o == 0 && quad_o == 0, "R6 reset state", int'(inph_o), 0);
    rst_ni = 1'b1;

    // Known cycle: I = -1736, Q = -246
    load_example();
    run_cycle(0, "example");
    chk(exp_val(1'b0) == -1736 && exp_val(1'b1) == -246, "R2 reference model", exp_val(1'b0), -1736);

    // Single nonzero group isolates each group's sum and weight
    fill_groups(0, 1000, 0, 0);
    run_cycle(0, "R1 single group 1");
    fill_groups(0, 0, 0, 17);
    run_cycle(0, "R1 single group 3");

    // Full-scale extremes
    fill_groups(4095, 4095, 0, 0);
    run_cycle(0, "R8 I max");
    chk(int'(inph_o) == 40950, "R8 I max value", int'(inph_o), 40950);
    fill_groups(0, 0, 4095, 4095);
    run_cycle(0, "R8 I min");
    chk(int'(inph_o) == -40950, "R8 I min value", int'(inph_o), -40950);
    fill_groups(0, 4095, 4095, 0);
    run_cycle(0, "R8 Q max");
    chk(int'(quad_o) == 40950, "R8 Q max value", int'(quad_o), 40950);
    fill_groups(4095, 0, 0, 4095);
    run_cycle(0, "R8 Q min");
    chk(int'(quad_o) == -40950, "R8 Q min value", int'(quad_o), -40950);
    fill_groups(4095, 4095, 4095, 4095);
    run_cycle(0, "R8 all full");

    // Idle clocks carry random samples that must be ignored
    load_example();
    run_cycle(60, "R5 gaps");

    // Mid-cycle reset discards partial sums
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      sample_i = 12'd4095;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(strobe_o == 1'b0 && inph_o == 0 && quad_o == 0, "R6 cleared by reset", int'(inph_o), 0);
    rst_ni = 1'b1;
    load_example();
    run_cycle(0, "R6 after mid-cycle reset");

    for (int n = 0; n < 30; n++) begin
      for (int k = 0; k < NS; k++) smp[k] = int'($urandom_range(4095));
      run_cycle((n % 3) * 25, "R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule